// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block drives one programmable clock output. Two clock-enable streams come in from elsewhere in the chip. One is a slow 32768 Hz base and the other is a fast 4 MHz base. One 8-bit control byte picks the source and sets two divide stages. The first stage is a coarse pre-divider that acts only on the fast base. The second is a power-of-two post-divider. The byte also holds a gate bit. The block produces two outputs. One is a one-cycle pulse per output period, for logic that runs on enables. The other is a 50% square wave for an output pin.

The system clock must be faster than either source enable. All counting happens on source ticks, so a source that pulses every k system cycles scales each period and each high time by k. A change to the divide codes or to the source select is held back until the current output period ends. This keeps the output free of runt or stretched pulses. Clearing the gate bit is the one exception: it forces both outputs low on the next clock.

Top module: `clkout_divider`

## Requirements
- R1: While reset is asserted, both `tickOut` and `waveOut` are 0.
- R2: Control bit 0 is the gate. When it reads 0, both outputs are 0 from the next clock onward, whatever the other bits and the source ticks do.
- R3: Control bits 3:1 hold a code N. The post-divider divides by 2^N, so codes 0 to 7 give ratios 1 to 128.
- R4: Control bit 4 selects the source: 0 counts `slowTick` and 1 counts `fastTick`.
- R5: Control bits 7:5 hold the pre-divider code. Codes 0 to 6 divide by 2^code. Code 7 divides by 122.
- R6: When bit 4 is 0, the pre-divider code has no effect on the output rate.
- R7: The output period, counted in selected source ticks, is the pre ratio times the post ratio. `tickOut` is high for exactly one clock per period, on the clock after the source tick that ends the period.
- R8: For a total ratio R of 2 or more, `waveOut` rises together with the `tickOut` pulse and stays high for R/2 source ticks of the R-tick period.
- R9: With a total ratio of 1, `tickOut` and `waveOut` both repeat each selected source tick, delayed by one clock.
- R10: A change to bits 7:1 while the gate is 1 takes effect only after the current period ends. The period in progress keeps its old length.
- R11: After the gate goes from 0 to 1, the first selected source tick starts a period at once: `tickOut` pulses and `waveOut` rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle enable from the 32768 Hz base |
| fastTick | input | 1 | One-cycle enable from the 4 MHz base |
| ctrlReg | input | 8 | Control byte: gate, post code, source select, pre code |
| tickOut | output | 1 | One-cycle pulse at the start of each output period |
| waveOut | output | 1 | 50% duty square wave at the output rate |

## Verification
The bench targets the pre-divide code 7. A design that used a plain power-of-two table there would give a 128-tick period instead of 122. It also checks that the pre code is ignored on the slow source. A design that applied it anyway would run 122 times too slow. The bench changes the ratio in the middle of a long period to confirm that the old period completes before the new one starts. A design without this holdback would cut the period short or stretch it. Ratio 1 is tested as a pass-through, because a half-period compare at that ratio can stick the wave high. The bench also drops the gate while the wave is high to confirm that the output is forced low within one clock.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // Field widths of the control byte
  localparam int PRE_W  = 3;
  localparam int POST_W = 3;

  // Bits 7:1 of the control byte, most significant field first
  typedef struct packed {
    logic [PRE_W-1:0]  preCode;
    logic              srcFast;
    logic [POST_W-1:0] postCode;
  } chanCfg_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic enable;
    logic tick;
    logic start;
    logic passThru;
  } dpStrobe_t;

endpackage

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int PRE_LAST = 122
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ctrlReg,
  input  logic             slowTick,
  input  logic             fastTick,
  input  logic             bound,
  output dpStrobe_t        st,
  output logic [CNT_W-1:0] endVal,
  output logic [CNT_W-1:0] halfVal
);

  localparam int RW      = CNT_W + 1;
  localparam int PRE_N   = 2 ** PRE_W;

  chanCfg_t cfg;
  logic     armed;
  logic     gateOn;
  logic [RW-1:0] preTable [PRE_N];
  logic [RW-1:0] preVal;
  logic [RW-1:0] ratio;

  assign gateOn = ctrlReg[0];

  // Pre-divide table: powers of two, except the last code
  for (genvar g = 0; g < PRE_N; g++) begin : gPre
    if (g == PRE_N - 1) begin : gLast
      assign preTable[g] = RW'(PRE_LAST);
    end else begin : gPow
      assign preTable[g] = RW'(1) << g;
    end
  end

  // Active configuration: follows the byte while idle, else reloads at a period end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg   <= '0;
      armed <= 1'b1;
    end else begin
      if (!gateOn || armed || bound) cfg <= chanCfg_t'(ctrlReg[7:1]);
      if (!gateOn)       armed <= 1'b1;
      else if (st.tick)  armed <= 1'b0;
    end
  end

  always_comb begin
    preVal  = cfg.srcFast ? preTable[cfg.preCode] : RW'(1);
    ratio   = preVal << cfg.postCode;
    endVal  = CNT_W'(ratio - RW'(1));
    halfVal = CNT_W'((ratio >> 1) - RW'(1));
  end

  always_comb begin
    st.enable   = gateOn;
    st.tick     = cfg.srcFast ? fastTick : slowTick;
    st.start    = armed;
    st.passThru = (ratio == RW'(1));
  end

endmodule

// File: rtl/clkout_dp.sv
module clkout_dp
  import clkout_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic [CNT_W-1:0] endVal,
  input  logic [CNT_W-1:0] halfVal,
  output logic             bound,
  output logic             tickOut,
  output logic             waveOut
);

  logic [CNT_W-1:0] cnt;

  // Period end: the first tick after arming, or the tick on the last count
  assign bound = st.tick && (st.start || cnt == endVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      tickOut <= 1'b0;
      waveOut <= 1'b0;
    end else if (!st.enable) begin
      cnt     <= '0;
      tickOut <= 1'b0;
      waveOut <= 1'b0;
    end else begin
      tickOut <= bound;
      if (bound)        cnt <= '0;
      else if (st.tick) cnt <= cnt + 1'b1;
      if (st.passThru)                    waveOut <= bound;
      else if (bound)                     waveOut <= 1'b1;
      else if (st.tick && cnt == halfVal) waveOut <= 1'b0;
    end
  end

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_pkg::*;
#(
  parameter int PRE_LAST = 122
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic       fastTick,
  input  logic [7:0] ctrlReg,
  output logic       tickOut,
  output logic       waveOut
);

  localparam int PRE_POW   = 2 ** (2 ** PRE_W - 2);
  localparam int PRE_MAX   = (PRE_LAST > PRE_POW) ? PRE_LAST : PRE_POW;
  localparam int POST_MAX  = 2 ** (2 ** POST_W - 1);
  localparam int MAX_RATIO = PRE_MAX * POST_MAX;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  dpStrobe_t        st;
  logic [CNT_W-1:0] endVal;
  logic [CNT_W-1:0] halfVal;
  logic             bound;

  clkout_ctrl #(.CNT_W(CNT_W), .PRE_LAST(PRE_LAST)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlReg(ctrlReg),
    .slowTick(slowTick), .fastTick(fastTick), .bound(bound),
    .st(st), .endVal(endVal), .halfVal(halfVal)
  );

  clkout_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .endVal(endVal), .halfVal(halfVal),
    .bound(bound), .tickOut(tickOut), .waveOut(waveOut)
  );

endmodule

// File: rtl/clkout_divider_chk.sv
module clkout_divider_chk (
  input logic       clk,
  input logic       rstN,
  input logic       slowTick,
  input logic       fastTick,
  input logic [7:0] ctrlReg,
  input logic       tickOut,
  input logic       waveOut
);

  // R1: outputs low while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_low_R1: assert (!tickOut && !waveOut)
        else $error("outputs not low in reset");
    end
  end

  // R2: a cleared gate forces both outputs low on the next clock
  assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlReg[0]) |-> (!tickOut && !waveOut));

  // R7: every pulse follows a source tick
  assert_pulse_from_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(slowTick || fastTick));

  // R8: the wave only rises at a period start
  assert_wave_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waveOut) |-> tickOut);

  // R2: a pulse needs the gate set on the clock before
  assert_pulse_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(ctrlReg[0]));

endmodule

bind clkout_divider clkout_divider_chk uChk (.*);

// File: tb/sim_clkout_divider.sv
module sim_clkout_divider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slowTick = 1'b0;
  logic       fastTick = 1'b0;
  logic [7:0] ctrlReg = 8'h00;
  logic       tickOut;
  logic       waveOut;

  int slowGap = 4;
  int fastGap = 1;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  clkout_divider u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
    .ctrlReg(ctrlReg), .tickOut(tickOut), .waveOut(waveOut)
  );

  always #5 clk = ~clk;

  // Source tick generators, driven away from the active edge
  initial begin
    int sp = 0;
    int fp = 0;
    forever begin
      @(negedge clk);
      slowTick = (sp == 0);
      fastTick = (fp == 0);
      sp = (sp + 1 >= slowGap) ? 0 : sp + 1;
      fp = (fp + 1 >= fastGap) ? 0 : fp + 1;
    end
  end

  function automatic logic [7:0] mkCtrl(bit en, bit fast, int pre, int post);
    return {3'(pre), fast, 3'(post), en};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic syncPulse(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (tickOut) begin ok = 1'b1; break; end
    end
  endtask

  // Called on a pulse cycle: cycles to next pulse, wave-high cycles in between
  task automatic measure(output int gap, output int hi);
    hi  = int'(waveOut);
    gap = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      gap++;
      if (tickOut) break;
      hi += int'(waveOut);
    end
  endtask

  task automatic runRatio(string req, logic [7:0] v, int expGap, int expHi);
    bit ok;
    int gap, hi;
    ctrlReg = 8'h00;
    repeat (3) @(negedge clk);
    ctrlReg = v;
    syncPulse(ok);
    check(req, "first pulse seen", int'(ok), 1);
    measure(gap, hi);
    check(req, "period cycles", gap, expGap);
    check(req, "high cycles", hi, expHi);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", "tickOut in reset", int'(tickOut), 0);
    check("R1", "waveOut in reset", int'(waveOut), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_gateOff;
    int highs = 0;
    fastGap = 1;
    ctrlReg = mkCtrl(1'b0, 1'b1, 0, 0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      highs += int'(tickOut) + int'(waveOut);
    end
    check("R2", "highs with gate clear", highs, 0);
  endtask

  task automatic t_slowBypass;
    slowGap = 2; fastGap = 1;
    // pre code 7 must be ignored on the slow source: R=8 ticks, 2 cycles each
    runRatio("R6", mkCtrl(1'b1, 1'b0, 7, 3), 16, 8);
  endtask

  task automatic t_preLast;
    fastGap = 1;
    runRatio("R5", mkCtrl(1'b1, 1'b1, 7, 0), 122, 61);
  endtask

  task automatic t_mixed;
    fastGap = 1;
    runRatio("R7", mkCtrl(1'b1, 1'b1, 2, 2), 16, 8);
    runRatio("R3", mkCtrl(1'b1, 1'b1, 6, 7), 8192, 4096);
    runRatio("R8", mkCtrl(1'b1, 1'b1, 0, 5), 32, 16);
  endtask

  task automatic t_passThru;
    fastGap = 2;
    runRatio("R9", mkCtrl(1'b1, 1'b1, 0, 0), 2, 1);
    slowGap = 5;
    runRatio("R4", mkCtrl(1'b1, 1'b0, 3, 0), 5, 1);
    fastGap = 1;
  endtask

  task automatic t_boundary;
    bit ok;
    int gap = 0;
    int early = 0;
    int hi;
    int gap2;
    fastGap = 1;
    ctrlReg = 8'h00;
    repeat (3) @(negedge clk);
    ctrlReg = mkCtrl(1'b1, 1'b1, 0, 6);
    syncPulse(ok);
    check("R10", "first pulse seen", int'(ok), 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      gap++;
      early += int'(tickOut);
    end
    check("R10", "no pulse before change", early, 0);
    ctrlReg = mkCtrl(1'b1, 1'b1, 0, 1);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      gap++;
      if (tickOut) break;
    end
    check("R10", "old period completes", gap, 64);
    measure(gap2, hi);
    check("R10", "new period", gap2, 2);
    check("R10", "new high", hi, 1);
  endtask

  task automatic t_start;
    int gap, hi;
    fastGap = 1;
    ctrlReg = mkCtrl(1'b0, 1'b1, 0, 2);
    repeat (3) @(negedge clk);
    ctrlReg[0] = 1'b1;
    @(negedge clk);
    check("R11", "pulse on first tick", int'(tickOut), 1);
    check("R11", "wave high on first tick", int'(waveOut), 1);
    measure(gap, hi);
    check("R11", "period after start", gap, 4);
  endtask

  task automatic t_gateMid;
    bit ok;
    int highs = 0;
    fastGap = 1;
    ctrlReg = 8'h00;
    repeat (3) @(negedge clk);
    ctrlReg = mkCtrl(1'b1, 1'b1, 0, 4);
    syncPulse(ok);
    repeat (2) @(negedge clk);
    check("R8", "wave high mid period", int'(waveOut), 1);
    ctrlReg[0] = 1'b0;
    @(negedge clk);
    check("R2", "wave low after gate clear", int'(waveOut), 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      highs += int'(tickOut) + int'(waveOut);
    end
    check("R2", "held low", highs, 0);
  endtask

  initial begin
    t_reset();
    t_gateOff();
    t_slowBypass();
    t_preLast();
    t_mixed();
    t_passThru();
    t_boundary();
    t_start();
    t_gateMid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule